// File: doc/BRIEF.md
# HCI UART Packet Framer

This block sits behind a UART receiver on the host side of a Bluetooth controller link. It takes one byte per cycle from a valid-qualified byte stream and cuts it into whole host-controller packets. The first byte of each packet names its kind: command, asynchronous (ACL) data, synchronous data or event. From that kind the block knows how many header bytes follow and where the payload length sits inside them. It then counts out the payload and marks the last byte.

Bytes are forwarded as a framed stream with backpressure, one beat per byte. Every beat carries the packet kind. The first beat carries a start marker and the last beat carries an end marker. Commands in the vendor-specific opcode group are flagged. Bytes that cannot start a packet are dropped and counted. ACL packets that declare an oversize payload are cut off, and their declared bytes are skipped. A byte that arrives while the output is stalled is lost, and this is reported with an overflow pulse. The parser keeps its place in the packet.

Top module: `hci_packet_framer`

## Requirements
- R1: After reset, out_valid, len_err and overflow are 0, discard_count is 0, and the parser waits for a type byte.
- R2: Type bytes 0x01 (command), 0x02 (ACL data), 0x03 (synchronous data) and 0x04 (event) open a packet. The type byte itself is the first output beat, with out_sop=1. On every beat of the packet, out_kind equals the low three bits of the type byte.
- R3: The header length depends on the kind: 3 bytes for a command, 4 for ACL, 3 for synchronous data and 2 for an event. A packet produces exactly 1 + header + payload beats, and out_eop is set only on the last of them.
- R4: The payload length is read from a fixed place for each kind. For a command it is the third header byte (8 bits). For synchronous data it is the third header byte (8 bits). For an event it is the second header byte (8 bits). For ACL it is the third and fourth header bytes, a 16-bit little-endian value. Header and payload bytes pass out unchanged and in order.
- R5: A declared payload length of zero puts out_eop on the last header beat.
- R6: A command's second header byte is the high byte of its opcode. When bits 7:2 of that byte equal 0x3F (opcode group 0x3F), out_vendor is 1 on the end beat. For any other group, out_vendor is 0.
- R7: A byte that is not a valid type byte and arrives while the parser is waiting for one produces no output. Each such byte adds one to discard_count, which saturates at its maximum value.
- R8: An ACL length above MAX_ACL_LEN (1024) ends the packet on its last header beat, with out_eop=1 and out_abort=1. In the same cycle, len_err pulses for one cycle. The next declared-length bytes are skipped: they produce no output and are not counted as discards. Parsing then resumes. A length of exactly 1024 is accepted in full.
- R9: While out_valid=1 and out_ready=0, the output beat is held stable. An input byte that arrives in this state is dropped, overflow pulses in the following cycle, and the parser state does not change.
- R10: A type byte that arrives directly after a packet's last byte starts the next packet with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Beat byte |
| out_sop | output | 1 | First beat of a packet (type byte) |
| out_eop | output | 1 | Last beat of a packet |
| out_kind | output | 3 | Packet kind: 1 command, 2 ACL, 3 synchronous, 4 event |
| out_vendor | output | 1 | Vendor-specific command, valid on the end beat |
| out_abort | output | 1 | Packet cut off by a length error |
| len_err | output | 1 | One-cycle pulse on an oversize ACL length |
| overflow | output | 1 | One-cycle pulse after an input byte was lost to backpressure |
| discard_count | output | DISC_W | Saturating count of discarded non-type bytes |

## Verification
The bench drives packets of every kind back to back. It targets the 16-bit ACL length with a nonzero high byte, zero-length payloads, and an opcode group one below the vendor value. A design that read the length from the wrong header byte, or swapped its byte order, would end packets early or late. A wrong group compare would set or miss the vendor flag. It also sends an ACL length one above the limit, followed by type-like bytes. A design that failed to skip the declared bytes would open phantom packets or inflate the discard count. A length of exactly the limit checks for an off-by-one. A byte sent into a stalled output checks that the held beat stays put and that the lost byte does not shift the parser by one position.

// File: rtl/hci_framer_pkg.sv
package hci_framer_pkg;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_CMD  = 3'd1,
        KIND_ACL  = 3'd2,
        KIND_SYNC = 3'd3,
        KIND_EVT  = 3'd4
    } pkt_kind_e;

    typedef enum logic [1:0] {
        PS_HUNT,
        PS_HDR,
        PS_PAY,
        PS_DROP
    } parse_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sop;
        logic       eop;
        pkt_kind_e  kind;
        logic       vendor;
        logic       abort;
    } beat_t;

    localparam logic [5:0] VENDOR_GROUP = 6'h3F;

    function automatic pkt_kind_e kind_of(input logic [7:0] code);
        case (code)
            8'h01:   return KIND_CMD;
            8'h02:   return KIND_ACL;
            8'h03:   return KIND_SYNC;
            8'h04:   return KIND_EVT;
            default: return KIND_NONE;
        endcase
    endfunction

    function automatic logic [2:0] header_bytes(input pkt_kind_e kind);
        case (kind)
            KIND_CMD:  return 3'd3;
            KIND_ACL:  return 3'd4;
            KIND_SYNC: return 3'd3;
            KIND_EVT:  return 3'd2;
            default:   return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/hci_type_decode.sv
module hci_type_decode
    import hci_framer_pkg::*;
(
    input  logic [7:0] code,
    output logic       known,
    output pkt_kind_e  kind
);

    always_comb begin
        kind  = kind_of(code);
        known = (kind != KIND_NONE);
    end

endmodule

// File: rtl/hci_frame_parser.sv
module hci_frame_parser
    import hci_framer_pkg::*;
#(
    parameter int MAX_ACL_LEN = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic [7:0] in_byte,
    output logic       emit,
    output beat_t      beat,
    output logic       discard_hit,
    output logic       len_err
);

    localparam int LEN_W = 16;

    parse_state_e     state_q;
    pkt_kind_e        kind_q;
    logic [2:0]       hdr_idx_q;
    logic [7:0]       len_lo_q;
    logic [LEN_W-1:0] remain_q;
    logic             vendor_q;

    logic             known;
    pkt_kind_e        new_kind;
    logic [2:0]       hdr_last;
    logic             at_last_hdr;
    logic [LEN_W-1:0] full_len;
    logic             too_long;
    logic             vendor_now;

    hci_type_decode u_decode (
        .code  (in_byte),
        .known (known),
        .kind  (new_kind)
    );

    always_comb begin
        hdr_last    = header_bytes(kind_q) - 3'd1;
        at_last_hdr = (state_q == PS_HDR) && (hdr_idx_q == hdr_last);
        full_len    = (kind_q == KIND_ACL) ? {in_byte, len_lo_q} : {8'h00, in_byte};
        too_long    = (kind_q == KIND_ACL) && (full_len > LEN_W'(MAX_ACL_LEN));
        vendor_now  = vendor_q ||
                      ((state_q == PS_HDR) && (kind_q == KIND_CMD) &&
                       (hdr_idx_q == 3'd1) && (in_byte[7:2] == VENDOR_GROUP));

        beat.data   = in_byte;
        beat.sop    = (state_q == PS_HUNT);
        beat.kind   = (state_q == PS_HUNT) ? new_kind : kind_q;
        beat.vendor = (state_q == PS_HUNT) ? 1'b0 : vendor_now;
        beat.abort  = at_last_hdr && too_long;
        beat.eop    = (at_last_hdr && (too_long || (full_len == '0))) ||
                      ((state_q == PS_PAY) && (remain_q == LEN_W'(1)));

        emit        = step && ((state_q == PS_HDR) || (state_q == PS_PAY) ||
                               ((state_q == PS_HUNT) && known));
        discard_hit = step && (state_q == PS_HUNT) && !known;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_HUNT;
            kind_q    <= KIND_NONE;
            hdr_idx_q <= '0;
            len_lo_q  <= '0;
            remain_q  <= '0;
            vendor_q  <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            len_err <= step && at_last_hdr && too_long;
            if (step) begin
                case (state_q)
                    PS_HUNT: begin
                        if (known) begin
                            state_q   <= PS_HDR;
                            kind_q    <= new_kind;
                            hdr_idx_q <= '0;
                            vendor_q  <= 1'b0;
                        end
                    end
                    PS_HDR: begin
                        hdr_idx_q <= hdr_idx_q + 3'd1;
                        vendor_q  <= vendor_now;
                        if (hdr_idx_q == 3'd2) begin
                            len_lo_q <= in_byte;
                        end
                        if (at_last_hdr) begin
                            if (too_long) begin
                                state_q  <= PS_DROP;
                                remain_q <= full_len;
                            end else if (full_len == '0) begin
                                state_q  <= PS_HUNT;
                            end else begin
                                state_q  <= PS_PAY;
                                remain_q <= full_len;
                            end
                        end
                    end
                    PS_PAY, PS_DROP: begin
                        remain_q <= remain_q - LEN_W'(1);
                        if (remain_q == LEN_W'(1)) begin
                            state_q <= PS_HUNT;
                        end
                    end
                    default: state_q <= PS_HUNT;
                endcase
            end
        end
    end

    // R3: a payload or skip phase always has bytes left to count
    assert_remaining_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_PAY) || (state_q == PS_DROP)) |-> (remain_q != '0))
        else $error("payload counter empty inside a packet");

    // R8: a length error always lands the parser in the skip phase of an ACL packet
    assert_abort_enters_drop_R8: assert property (@(posedge clk) disable iff (rst)
        len_err |-> ((state_q == PS_DROP) && (kind_q == KIND_ACL)))
        else $error("length error without skip phase");

endmodule

// File: rtl/hci_beat_stage.sv
module hci_beat_stage
    import hci_framer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  out_ready,
    input  logic  emit,
    input  beat_t beat_in,
    output logic  accept,
    output logic  out_valid,
    output beat_t beat_q,
    output logic  overflow
);

    always_comb begin
        accept = in_valid && (!out_valid || out_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            beat_q    <= '0;
            overflow  <= 1'b0;
        end else begin
            overflow <= in_valid && !accept;
            if (emit) begin
                out_valid <= 1'b1;
                beat_q    <= beat_in;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R9: a stalled beat stays valid and unchanged
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(beat_q)))
        else $error("stalled beat changed");

    // R9: a lost byte is only reported after a stalled cycle
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(out_valid && !out_ready))
        else $error("overflow without stall");

    // R9: the parser never emits into an occupied slot
    assert_emit_slot_free_R9: assert property (@(posedge clk) disable iff (rst)
        emit |-> (!out_valid || out_ready))
        else $error("beat emitted over a stalled beat");

endmodule

// File: rtl/hci_discard_counter.sv
module hci_discard_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (hit && (count != {W{1'b1}})) begin
            count <= count + W'(1);
        end
    end

    // R7: the count moves only on a discarded byte
    assert_discard_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(count))
        else $error("discard count moved without a discard");

endmodule

// File: rtl/hci_packet_framer.sv
module hci_packet_framer
    import hci_framer_pkg::*;
#(
    parameter int MAX_ACL_LEN = 1024,
    parameter int DISC_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [2:0]        out_kind,
    output logic              out_vendor,
    output logic              out_abort,
    output logic              len_err,
    output logic              overflow,
    output logic [DISC_W-1:0] discard_count
);

    logic  accept;
    logic  emit;
    logic  discard_hit;
    beat_t next_beat;
    beat_t held_beat;

    hci_frame_parser #(.MAX_ACL_LEN(MAX_ACL_LEN)) u_parser (
        .clk         (clk),
        .rst         (rst),
        .step        (accept),
        .in_byte     (in_byte),
        .emit        (emit),
        .beat        (next_beat),
        .discard_hit (discard_hit),
        .len_err     (len_err)
    );

    hci_beat_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .emit      (emit),
        .beat_in   (next_beat),
        .accept    (accept),
        .out_valid (out_valid),
        .beat_q    (held_beat),
        .overflow  (overflow)
    );

    hci_discard_counter #(.W(DISC_W)) u_discard (
        .clk   (clk),
        .rst   (rst),
        .hit   (discard_hit),
        .count (discard_count)
    );

    always_comb begin
        out_data   = held_beat.data;
        out_sop    = held_beat.sop;
        out_eop    = held_beat.eop;
        out_kind   = held_beat.kind;
        out_vendor = held_beat.vendor;
        out_abort  = held_beat.abort;
    end

    // R8: the length error pulse coincides with the cut-off end beat
    assert_len_err_beat_R8: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (out_valid && out_eop && out_abort))
        else $error("length error without abort beat");

    // R2: a start beat carries the type byte and its kind tag
    assert_sop_kind_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> ((out_data[2:0] == out_kind) && (out_data[7:3] == 5'd0)))
        else $error("start beat kind mismatch");

endmodule

// File: tb/test_hci_packet_framer.sv
module test_hci_packet_framer;

    localparam int LOGMAX = 2048;

    typedef struct packed {
        logic [7:0]  ind;
        logic [31:0] hdr;
        logic [2:0]  hlen;
        logic [15:0] plen;
        logic        vend;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h01, 32'h0002FC01, 3'd3, 16'd2,   1'b1},
        '{8'h01, 32'h00000C03, 3'd3, 16'd0,   1'b0},
        '{8'h02, 32'h00050001, 3'd4, 16'd5,   1'b0},
        '{8'h02, 32'h01000002, 3'd4, 16'd256, 1'b0},
        '{8'h03, 32'h00030001, 3'd3, 16'd3,   1'b0},
        '{8'h04, 32'h0000040E, 3'd2, 16'd4,   1'b0},
        '{8'h01, 32'h0001F801, 3'd3, 16'd1,   1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_ready = 1'b1;
    logic       out_valid, out_sop, out_eop, out_vendor, out_abort, len_err, overflow;
    logic [7:0] out_data;
    logic [2:0] out_kind;
    logic [7:0] discard_count;

    int nchk = 0;
    int nfail = 0;
    int log_n = 0;
    int lerr_n = 0;
    int ovf_n = 0;
    logic [7:0] log_data [LOGMAX];
    logic       log_sop  [LOGMAX];
    logic       log_eop  [LOGMAX];
    logic       log_vend [LOGMAX];
    logic       log_abt  [LOGMAX];
    logic [2:0] log_kind [LOGMAX];

    always #4 clk = ~clk;

    hci_packet_framer i_hci_packet_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_kind(out_kind),
        .out_vendor(out_vendor), .out_abort(out_abort), .len_err(len_err),
        .overflow(overflow), .discard_count(discard_count)
    );

    always @(negedge clk) begin
        if (out_valid && out_ready && log_n < LOGMAX) begin
            log_data[log_n] = out_data;
            log_sop[log_n]  = out_sop;
            log_eop[log_n]  = out_eop;
            log_vend[log_n] = out_vendor;
            log_abt[log_n]  = out_abort;
            log_kind[log_n] = out_kind;
            log_n++;
        end
        if (len_err)  lerr_n++;
        if (overflow) ovf_n++;
    end

    function automatic logic [7:0] pay(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        log_n  = 0;
        lerr_n = 0;
        ovf_n  = 0;
    endtask

    task automatic send_vec(input vec_t v);
        send(v.ind);
        for (int i = 0; i < int'(v.hlen); i++) send(v.hdr[8*i +: 8]);
        for (int i = 0; i < int'(v.plen); i++) send(pay(i));
    endtask

    task automatic check_vec(input vec_t v);
        int exp_n = 1 + int'(v.hlen) + int'(v.plen);
        int sops = 0;
        int eops = 0;
        int bad = 0;
        int kbad = 0;
        int abt = 0;
        chk(log_n == exp_n, "R3 beat count", log_n, exp_n);
        if (log_n != exp_n) return;
        chk(log_data[0] == v.ind && log_sop[0], "R2 type byte on start beat", int'(log_data[0]), int'(v.ind));
        for (int i = 0; i < exp_n; i++) begin
            if (log_sop[i]) sops++;
            if (log_eop[i]) eops++;
            if (log_abt[i]) abt++;
            if (log_kind[i] != v.ind[2:0]) kbad++;
        end
        chk(kbad == 0, "R2 kind tag on every beat", kbad, 0);
        chk(sops == 1 && eops == 1 && log_eop[exp_n-1], "R3 single start and end marker", eops, 1);
        for (int i = 0; i < int'(v.hlen); i++)
            if (log_data[1+i] != v.hdr[8*i +: 8]) bad++;
        for (int i = 0; i < int'(v.plen); i++)
            if (log_data[1+int'(v.hlen)+i] != pay(i)) bad++;
        chk(bad == 0, "R4 header and payload bytes", bad, 0);
        chk(log_vend[exp_n-1] == v.vend, "R6 vendor flag", int'(log_vend[exp_n-1]), int'(v.vend));
        chk(abt == 0 && lerr_n == 0, "R8 no abort on legal length", abt + lerr_n, 0);
        if (v.plen == 0) chk(log_eop[v.hlen], "R5 end on last header byte", int'(log_eop[v.hlen]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !len_err && !overflow, "R1 outputs idle after reset", int'(out_valid), 0);
        chk(discard_count == 0, "R1 discard count cleared", int'(discard_count), 0);
        @(posedge clk);
        #1;

        // table walk, packets back to back within each vector
        for (int v = 0; v < 7; v++) begin
            clear_log();
            send_vec(VECS[v]);
            idle(3);
            check_vec(VECS[v]);
        end

        // R10: two event packets with no gap; first has zero payload (R5)
        clear_log();
        send(8'h04); send(8'h0E); send(8'h00);
        send(8'h04); send(8'h0F); send(8'h01); send(8'h33);
        idle(3);
        chk(log_n == 7, "R10 back-to-back beat count", log_n, 7);
        chk(log_sop[0] && log_eop[2] && log_sop[3] && log_eop[6] && !log_eop[1] && !log_sop[4],
            "R10 markers of adjacent packets", int'(log_sop[3]), 1);
        chk(log_data[6] == 8'h33, "R10 second payload byte", int'(log_data[6]), 'h33);

        // R7: non-type bytes dropped and counted
        clear_log();
        d0 = int'(discard_count);
        send(8'h00); send(8'h55); send(8'hFF); send(8'h05);
        send(8'h04); send(8'h0E); send(8'h00);
        idle(3);
        chk(int'(discard_count) == d0 + 4, "R7 discard count", int'(discard_count), d0 + 4);
        chk(log_n == 3 && log_data[0] == 8'h04, "R7 no output from junk", log_n, 3);

        // R8: ACL length 0x0401 is one above the limit
        clear_log();
        d0 = int'(discard_count);
        send(8'h02); send(8'h01); send(8'h00); send(8'h01); send(8'h04);
        for (int i = 0; i < 1025; i++) send(8'h04);
        send(8'h04); send(8'h0E); send(8'h00);
        idle(3);
        chk(log_n == 8, "R8 skipped bytes produce no beats", log_n, 8);
        chk(log_eop[4] && log_abt[4], "R8 abort on last header beat", int'(log_abt[4]), 1);
        chk(lerr_n == 1, "R8 single length error pulse", lerr_n, 1);
        chk(int'(discard_count) == d0, "R8 skipped bytes not counted as discards", int'(discard_count), d0);
        chk(log_sop[5] && log_data[5] == 8'h04, "R8 parsing resumes after skip", int'(log_data[5]), 4);

        // R8 boundary: length exactly 1024 accepted
        clear_log();
        send(8'h02); send(8'h01); send(8'h00); send(8'h00); send(8'h04);
        for (int i = 0; i < 1024; i++) send(pay(i));
        idle(3);
        chk(log_n == 1029 && log_eop[1028] && !log_abt[1028], "R8 limit length accepted", log_n, 1029);
        chk(lerr_n == 0, "R8 no length error at limit", lerr_n, 0);

        // R9: byte sent into a stalled output
        clear_log();
        out_ready = 1'b0;
        send(8'h04);
        send(8'h77);
        @(negedge clk);
        chk(overflow == 1'b1, "R9 overflow pulse", int'(overflow), 1);
        chk(out_valid && out_data == 8'h04 && out_sop, "R9 stalled beat held", int'(out_data), 4);
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        send(8'h0E); send(8'h02); send(8'hAA); send(8'hBB);
        idle(3);
        chk(log_n == 5 && log_data[1] == 8'h0E && log_data[4] == 8'hBB && log_eop[4],
            "R9 parser state kept across lost byte", log_n, 5);
        chk(ovf_n == 1, "R9 one overflow pulse", ovf_n, 1);

        // R7: saturation of the discard count
        for (int i = 0; i < 300; i++) send(8'h99);
        idle(2);
        chk(discard_count == 8'hFF, "R7 discard count saturates", int'(discard_count), 255);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule